// File: doc/BRIEF.md
# Circular Cell Buffer Address Generator

This block produces 20-bit word addresses into external memory for a receive path that stores fixed-size cells, 32 words each, in a circular buffer. Software programs one 16-bit configuration register. That register holds a 2-bit depth code and an 11-bit base field. The base field gives the upper address bits of the buffer start.

While the receiver is enabled, each word strobe moves a 5-bit word offset forward within the current cell. An end-of-cell pulse advances the cell write pointer, which wraps at the configured depth. The same pulse returns the offset to zero. The pointer is also visible through a read-only 16-bit status view.

The address is built by overlaying fields, not by adding them. The base sits in bits 19:9, the pointer (masked to the depth) in bits 11:5, and the offset in bits 4:0. A buffer that is aligned to its own size therefore never needs a carry chain.

Top module: `cellbuf_addr_gen`

## Requirements
- R1: A write to the configuration register stores the depth code from write bits 1:0 and the base from write bits 12:2. The read view returns these fields at the same positions. Bits 15:13 always read 0, and the register is 0 after reset.
- R2: The status view carries the write pointer in bits 6:0 and zero in bits 15:7. It reads 0 after reset.
- R3: With the receiver enabled, the pointer rises by exactly one on each cycle where end-of-cell is high. On every other cycle it holds its value.
- R4: The depth code sets where the pointer wraps: 00 gives 16 cells (0 to 15), 01 gives 32, 10 gives 64, and 11 gives 128. The cell after the last one is cell 0.
- R5: While the receiver is disabled, the pointer is held at 0 and end-of-cell pulses have no effect.
- R6: With the receiver enabled, each word strobe raises the word offset by one. The offset saturates at 31. An end-of-cell pulse sets it to 0, and this wins over a word strobe in the same cycle.
- R7: Word strobes received while the receiver is disabled are ignored, and the offset reads 0.
- R8: The word address equals (base << 9) | ((pointer & (depth-1)) << 5) | offset.
- R9: A base that is not aligned to the buffer size is combined by bitwise OR. No carry passes from the pointer field into the base field.
- R10: A change to the depth code takes effect at once in the address mask and at the next pointer advance. That advance produces (pointer+1) masked to the new depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Receiver enable |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration register read view |
| ptr_rdata | output | 16 | Pointer status read view |
| word_stb | input | 1 | One memory word of the current cell written |
| cell_end | input | 1 | Current cell complete |
| word_addr | output | 20 | Word address in external memory |

## Verification
The assertions assume that end-of-cell and word-strobe pulses last one cycle each. They also assume that the configuration register may change at any time, so the properties on the base field use only the address bits that lie above the widest pointer overlay. The stimulus changes configuration and enable only at the falling edge, and it pulses each strobe for exactly one cycle. It also deliberately writes a misaligned base and changes the depth code while enabled, so that the overlay and re-mask rules are exercised inside those assumptions.

// File: rtl/cellbuf_addr_gen.sv
module cellbuf_addr_gen #(
  parameter int BASE_W = 11,
  parameter int SIZE_W = 2,
  parameter int PTR_W  = 7,
  parameter int OFF_W  = 5,
  parameter int REG_W  = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rx_en,
  input  logic                      cfg_we,
  input  logic [REG_W-1:0]          cfg_wdata,
  output logic [REG_W-1:0]          cfg_rdata,
  output logic [REG_W-1:0]          ptr_rdata,
  input  logic                      word_stb,
  input  logic                      cell_end,
  output logic [BASE_W+OFF_W+3:0]   word_addr
);
  localparam int ADDR_W  = BASE_W + OFF_W + 4;
  localparam int SHIFT_B = OFF_W + 4;
  localparam logic [OFF_W-1:0] OFF_MAX = '1;

  logic [SIZE_W-1:0] size_q;
  logic [BASE_W-1:0] base_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [OFF_W-1:0]  off_q;
  logic [PTR_W:0]    depth;
  logic [PTR_W-1:0]  mask;
  logic [PTR_W-1:0]  ptr_inc;

  assign depth   = (PTR_W+1)'(16) << size_q;
  assign mask    = PTR_W'(depth - 1'b1);
  assign ptr_inc = (ptr_q + 1'b1) & mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= '0;
      base_q <= '0;
    end else if (cfg_we) begin
      size_q <= cfg_wdata[SIZE_W-1:0];
      base_q <= cfg_wdata[SIZE_W+BASE_W-1:SIZE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en)  ptr_q <= '0;
    else if (cell_end)     ptr_q <= ptr_inc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en)             off_q <= '0;
    else if (cell_end)                off_q <= '0;
    else if (word_stb && off_q != OFF_MAX) off_q <= off_q + 1'b1;
  end

  assign cfg_rdata = REG_W'({base_q, size_q});
  assign ptr_rdata = REG_W'(ptr_q);
  assign word_addr = (ADDR_W'(base_q) << SHIFT_B)
                   | (ADDR_W'(ptr_q & mask) << OFF_W)
                   | ADDR_W'(off_q);
endmodule

// File: rtl/cellbuf_addr_gen_chk.sv
module cellbuf_addr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_en,
  input logic        cell_end,
  input logic        word_stb,
  input logic [15:0] cfg_rdata,
  input logic [15:0] ptr_rdata,
  input logic [19:0] word_addr
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[15:13] == 3'b000);

  a_r2_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rdata[15:7] == 9'd0);

  a_r3_hold_without_end: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !cell_end) |=> $stable(ptr_rdata));

  a_r5_cleared_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (ptr_rdata == 16'd0));

  a_r6_offset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && cell_end) |=> (word_addr[4:0] == 5'd0));

  a_r6_offset_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !cell_end && word_addr[4:0] == 5'd31) |=> (word_addr[4:0] == 5'd31));

  a_r7_offset_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (word_addr[4:0] == 5'd0));

  a_r8_base_upper_bits: assert property (@(posedge clk) disable iff (!rst_n)
    word_addr[19:12] == cfg_rdata[12:5]);
endmodule

bind cellbuf_addr_gen cellbuf_addr_gen_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cell_end(cell_end),
  .word_stb(word_stb), .cfg_rdata(cfg_rdata), .ptr_rdata(ptr_rdata),
  .word_addr(word_addr)
);

// File: tb/cellbuf_addr_gen_tb.sv
module cellbuf_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [15:0] ptr_rdata;
  logic        word_stb = 1'b0;
  logic        cell_end = 1'b0;
  logic [19:0] word_addr;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  cellbuf_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ptr_rdata(ptr_rdata),
    .word_stb(word_stb), .cell_end(cell_end), .word_addr(word_addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [1:0] sz, input logic [10:0] base);
    cfg_wdata = {3'b000, base, sz};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cells(input int n);
    for (int i = 0; i < n; i++) begin
      cell_end = 1'b1;
      @(negedge clk);
      cell_end = 1'b0;
    end
  endtask

  task automatic words(input int n);
    for (int i = 0; i < n; i++) begin
      word_stb = 1'b1;
      @(negedge clk);
      word_stb = 1'b0;
    end
  endtask

  task automatic restart();
    rx_en = 1'b0;
    @(negedge clk);
    rx_en = 1'b1;
  endtask

  task automatic t_reset();
    chk("R1 reset cfg", cfg_rdata, 0);
    chk("R2 reset status", ptr_rdata, 0);
    chk("R8 reset addr", word_addr, 0);
  endtask

  task automatic t_cfg_rw();
    cfg_wdata = 16'hFFFF;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R1 reserved bits", cfg_rdata, 16'h1FFF);
    wr_cfg(2'b10, 11'h123);
    chk("R1 readback", cfg_rdata, {3'b0, 11'h123, 2'b10});
  endtask

  task automatic t_advance();
    wr_cfg(2'b00, 11'h000);
    restart();
    @(negedge clk);
    chk("R3 hold idle", ptr_rdata, 0);
    cells(3);
    chk("R3 advance", ptr_rdata, 3);
    chk("R2 status upper", ptr_rdata[15:7], 0);
  endtask

  task automatic t_wrap();
    for (int s = 0; s < 4; s++) begin
      wr_cfg(s[1:0], 11'h000);
      restart();
      cells((16 << s) - 1);
      chk("R4 last cell", ptr_rdata, (16 << s) - 1);
      cells(1);
      chk("R4 wrap", ptr_rdata, 0);
    end
  endtask

  task automatic t_disable();
    wr_cfg(2'b01, 11'h000);
    restart();
    cells(5);
    rx_en = 1'b0;
    @(negedge clk);
    chk("R5 cleared", ptr_rdata, 0);
    cells(2);
    chk("R5 end ignored", ptr_rdata, 0);
    words(4);
    chk("R7 strobe ignored", word_addr[4:0], 0);
    rx_en = 1'b1;
  endtask

  task automatic t_offset();
    restart();
    words(7);
    chk("R6 count", word_addr[4:0], 7);
    words(30);
    chk("R6 saturate", word_addr[4:0], 31);
    word_stb = 1'b1;
    cell_end = 1'b1;
    @(negedge clk);
    word_stb = 1'b0;
    cell_end = 1'b0;
    chk("R6 end wins", word_addr[4:0], 0);
    chk("R3 end with strobe", ptr_rdata, 1);
  endtask

  task automatic t_addr();
    wr_cfg(2'b10, 11'h123);
    restart();
    cells(5);
    words(3);
    chk("R8 address", word_addr, 20'h246A3);
  endtask

  task automatic t_misaligned();
    wr_cfg(2'b01, 11'h007);
    restart();
    cells(31);
    chk("R9 or combine", word_addr, 20'h00FE0);
  endtask

  task automatic t_resize();
    wr_cfg(2'b11, 11'h000);
    restart();
    cells(20);
    wr_cfg(2'b00, 11'h000);
    chk("R10 raw pointer kept", ptr_rdata, 20);
    chk("R10 address masked", word_addr, 20'h00080);
    cells(1);
    chk("R10 remask on advance", ptr_rdata, 5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg_rw();
    t_advance();
    t_wrap();
    t_disable();
    t_offset();
    t_addr();
    t_misaligned();
    t_resize();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule